// File: doc/BRIEF.md
# PWM Timer Fault Capture Unit

This block watches for fault events on behalf of a PWM timer and turns them into a sticky flag and an interrupt request. The fault can come either from an external fault pin or from the digital result of an analog comparator. A select input picks the source. Whichever source is chosen goes through the same path: a flop synchronizer, an optional noise canceler and an edge detector whose polarity can be set.

A detected edge sets the fault flag, and the flag holds until it is cleared. There are two ways to clear it. The interrupt controller can acknowledge the interrupt, which clears the flag on the next clock edge. Software can write a one to the flag, which clears it one synchronization cycle later; writing a zero does nothing. If an edge and a clear happen together, the edge wins. The interrupt request is asserted only while the flag, the fault interrupt enable and the global interrupt enable are all set.

Top module: `pwm_fault_capture`

## Requirements
- R1: After reset, `fault_flag_o` and `irq_o` are both 0.
- R2: With `src_cmp_i` = 1 the comparator input feeds the fault path and the pin is ignored. With `src_cmp_i` = 0 the pin feeds it and the comparator is ignored. The comparator goes through the same noise canceler and edge logic as the pin.
- R3: With the noise canceler off, a qualifying input change applied before clock edge 0 first shows on `fault_flag_o` after clock edge 3. That is two synchronizer stages, one level register and one flag register.
- R4: With the noise canceler on (`filt_en_i` = 1), the same change first shows on `fault_flag_o` after clock edge 7, which is NC_DEPTH = 4 edges later than in R3. A change that holds for fewer than NC_DEPTH+1 consecutive synchronized samples is discarded.
- R5: `edge_rise_i` = 1 selects rising edges (0 to 1) as fault events. `edge_rise_i` = 0 selects falling edges (1 to 0). An edge of the other polarity does not set the flag.
- R6: `irq_ack_i` high at a clock edge clears the flag at that edge.
- R7: A write (`flag_wr_i` = 1) with `flag_wdata_i` = 1 at edge W clears the flag at edge W+1. A write with `flag_wdata_i` = 0 has no effect.
- R8: A fault event at the same edge as a clear (acknowledge or pending write) leaves the flag set.
- R9: `irq_o` is 1 exactly when `fault_flag_o`, `fault_ie_i` and `glob_ie_i` are all 1. It is combinational from these inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_pin_i | input | 1 | External fault pin, asynchronous |
| cmp_out_i | input | 1 | Comparator digital result, asynchronous |
| src_cmp_i | input | 1 | 1 = comparator is the fault source, 0 = pin |
| filt_en_i | input | 1 | Noise canceler enable |
| edge_rise_i | input | 1 | 1 = rising-edge event, 0 = falling-edge event |
| fault_ie_i | input | 1 | Fault interrupt enable |
| glob_ie_i | input | 1 | Global interrupt enable |
| flag_wr_i | input | 1 | Write strobe to the flag |
| flag_wdata_i | input | 1 | Written value; 1 requests a clear |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| fault_flag_o | output | 1 | Sticky fault flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: two synchronizer stages and a noise canceler depth of four. This makes the latencies of both the unfiltered path and the filtered path exact, so the bench can check them on the exact clock edge. A three-cycle pulse is short enough for the canceler to reject but long enough to pass when the canceler is off. With the unfiltered path, the event edge can be lined up with an acknowledge on the same clock edge, which tests the rule that a set beats a clear.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

    // Registered state of the edge detector and flag stage
    typedef struct packed {
        logic prev;      // filtered level one cycle earlier
        logic flag;      // sticky fault flag
        logic clr_pend;  // software clear waiting one cycle
    } flag_state_t;

endpackage

// File: rtl/pwm_fault_sync.sv
module pwm_fault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout_o = chain_q[STAGES-1];

    // R3
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[0] == $past(din_i));
endmodule

// File: rtl/pwm_fault_filter.sv
module pwm_fault_filter #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sample_i,
    output logic level_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.level = sample_i;
            st_d.cnt   = '0;
        end else if (sample_i == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_MAX) begin
            st_d.level = sample_i;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    // R4
    filt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && (st_q.level != $past(st_q.level))) |-> ($past(st_q.cnt) == CNT_MAX));
endmodule

// File: rtl/pwm_fault_flag.sv
module pwm_fault_flag
    import pwm_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rise_sel_i,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic ack_i,
    output logic flag_o
);
    flag_state_t st_d, st_q;
    logic        evt;
    logic        clr;

    always_comb begin
        evt  = rise_sel_i ? (level_i & ~st_q.prev) : (~level_i & st_q.prev);
        clr  = ack_i | st_q.clr_pend;
        st_d = st_q;
        st_d.prev     = level_i;
        st_d.clr_pend = wr_i & wdata_i;
        if (evt)      st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R5
    flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !$past(st_q.flag)) |-> $past(evt));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !evt) |=> !st_q.flag);

    // R7
    w1c_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.clr_pend && !evt) |=> !st_q.flag);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> st_q.flag);
endmodule

// File: rtl/pwm_fault_capture.sv
module pwm_fault_capture #(
    parameter int SYNC_STAGES = 2,
    parameter int NC_DEPTH    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_pin_i,
    input  logic cmp_out_i,
    input  logic src_cmp_i,
    input  logic filt_en_i,
    input  logic edge_rise_i,
    input  logic fault_ie_i,
    input  logic glob_ie_i,
    input  logic flag_wr_i,
    input  logic flag_wdata_i,
    input  logic irq_ack_i,
    output logic fault_flag_o,
    output logic irq_o
);
    logic raw_src;
    logic sync_lvl;
    logic filt_lvl;

    always_comb raw_src = src_cmp_i ? cmp_out_i : fault_pin_i;

    pwm_fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (raw_src),
        .dout_o (sync_lvl)
    );

    pwm_fault_filter #(.DEPTH(NC_DEPTH)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (filt_en_i),
        .sample_i (sync_lvl),
        .level_o  (filt_lvl)
    );

    pwm_fault_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (filt_lvl),
        .rise_sel_i (edge_rise_i),
        .wr_i       (flag_wr_i),
        .wdata_i    (flag_wdata_i),
        .ack_i      (irq_ack_i),
        .flag_o     (fault_flag_o)
    );

    always_comb irq_o = fault_flag_o & fault_ie_i & glob_ie_i;

    // R9
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_ie_i |-> !irq_o);

    // R9
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_ie_i |-> !irq_o);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!fault_flag_o && !irq_o));
endmodule

// File: tb/pwm_fault_capture_tb.sv
module pwm_fault_capture_tb;
    localparam int LAT_OFF = 4;
    localparam int LAT_ON  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 0, cmp = 0, src = 0, filt = 0, rise = 1;
    logic ie = 0, gie = 0, wr = 0, wdata = 0, ack = 0;
    logic flag, irq;
    int   checks = 0, errors = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    pwm_fault_capture u_dut (
        .clk(clk), .rst_n(rst_n), .fault_pin_i(pin), .cmp_out_i(cmp),
        .src_cmp_i(src), .filt_en_i(filt), .edge_rise_i(rise),
        .fault_ie_i(ie), .glob_ie_i(gie), .flag_wr_i(wr), .flag_wdata_i(wdata),
        .irq_ack_i(ack), .fault_flag_o(flag), .irq_o(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle_clear();
        tick(12);
        ack = 1; tick(1); ack = 0;
    endtask

    task automatic t_reset();
        chk("R1 flag", flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_latency_off();
        filt = 0; rise = 1; pin = 0; settle_clear();
        pin = 1; tick(LAT_OFF - 1);
        chk("R3 before", flag, 1'b0);
        tick(1);
        chk("R3 at", flag, 1'b1);
    endtask

    task automatic t_irq();
        ie = 0; gie = 1; #1; chk("R9 ie0", irq, 1'b0);
        ie = 1; gie = 0; #1; chk("R9 gie0", irq, 1'b0);
        ie = 1; gie = 1; #1; chk("R9 all", irq, 1'b1);
        ie = 0; gie = 0;
    endtask

    task automatic t_w1c();
        wr = 1; wdata = 0; tick(1); wr = 0; tick(3);
        chk("R7 write zero", flag, 1'b1);
        wr = 1; wdata = 1; tick(1); wr = 0; wdata = 0;
        chk("R7 one cycle", flag, 1'b1);
        tick(1);
        chk("R7 cleared", flag, 1'b0);
    endtask

    task automatic t_ack_and_set_wins();
        pin = 0; settle_clear();
        pin = 1; tick(LAT_OFF);
        chk("R6 set", flag, 1'b1);
        ack = 1; tick(1); ack = 0;
        chk("R6 ack", flag, 1'b0);
        pin = 0; settle_clear();
        pin = 1; tick(LAT_OFF - 1);
        ack = 1; tick(1); ack = 0;
        chk("R8 set wins", flag, 1'b1);
    endtask

    task automatic t_filter();
        pin = 0; filt = 1; settle_clear();
        pin = 1; tick(LAT_ON - 1);
        chk("R4 before", flag, 1'b0);
        tick(1);
        chk("R4 at", flag, 1'b1);
        pin = 0; settle_clear();
        pin = 1; tick(3); pin = 0; tick(15);
        chk("R4 glitch rejected", flag, 1'b0);
        filt = 0; settle_clear();
        pin = 1; tick(3); pin = 0; tick(10);
        chk("R4 glitch passes unfiltered", flag, 1'b1);
    endtask

    task automatic t_edge();
        rise = 0; pin = 0; settle_clear();
        pin = 1; tick(10);
        chk("R5 rising ignored", flag, 1'b0);
        pin = 0; tick(LAT_OFF);
        chk("R5 falling", flag, 1'b1);
        rise = 1; pin = 0; settle_clear();
    endtask

    task automatic t_source();
        src = 0; cmp = 0; pin = 0; settle_clear();
        cmp = 1; tick(10);
        chk("R2 cmp ignored", flag, 1'b0);
        cmp = 0; src = 1; filt = 1; settle_clear();
        cmp = 1; tick(LAT_ON - 1);
        chk("R2 cmp filtered before", flag, 1'b0);
        tick(1);
        chk("R2 cmp filtered at", flag, 1'b1);
        settle_clear();
        pin = 1; tick(12);
        chk("R2 pin ignored", flag, 1'b0);
        src = 0; filt = 0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1;
        tick(1);
        t_latency_off();
        t_irq();
        t_w1c();
        t_ack_and_set_wins();
        t_filter();
        t_edge();
        t_source();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule